// File: doc/BRIEF.md
# Two-Cache Write-Back Ownership Coherence Controller

This block keeps two private processor caches coherent over one shared snooped bus. Memory backs them through a single memory port. Each cache line is Invalid, Shared or Owned. A block owned by memory may sit read-only in both caches at once. A block owned by a cache is held dirty in that cache alone, and memory's copy of it goes stale. A processor write takes ownership with a bus command that invalidates every other copy. A remote read of an owned block is served by the owner, which writes the line back to memory in the same bus cycle.

Each processor drives a request port and holds its request until its response pulse arrives. The controller serves one transaction at a time. When a dirty line has to be evicted, a writeback goes out on the bus before the fill that reuses the frame. Memory is read combinationally through the memory port in the bus cycle that needs it. Both caches are direct-mapped and indexed by the low address bits.

Top module: `coh_wbown_top`

## Requirements
- R1: After reset, no response is pending, the bus command is idle (0) and memory is not written.
- R2: A read miss whose block no other cache owns issues bus command READ (1), returns the memory word and leaves a shared copy in the requester.
- R3: A read that hits a Shared or Owned line returns the cached word with no bus command.
- R4: A write to a Shared line issues INVALIDATE (3) and takes ownership. The other cache's copy becomes invalid, so the other cache's next read of that block misses with READ.
- R5: A write miss issues READ-FOR-OWNERSHIP (2). Any other copy, including an owned one, is invalidated and memory is not written.
- R6: A write to an owned or newly owned line never writes memory, so memory holds the older value until a writeback. Memory is written only in a WRITEBACK or READ bus cycle.
- R7: A READ of a block owned by the other cache gets its data from that cache. In the same cycle memory receives the owner's word at the block address, and the owner keeps a Shared copy: its next read hits, and its next write issues INVALIDATE.
- R8: A miss that maps onto an Owned line of another address first issues WRITEBACK (4) with the victim's address and data on the memory port. The miss's own bus command follows in the next cycle.
- R9: When both ports request at once, port 0 is served first and port 1 after it. The bus source output names the port being served.
- R10: Each transaction ends with a one-cycle pulse on the requester's bit of the response valid output. The response carries the read word, or for a write the word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Per-port request, held until the response |
| reqWrite | input | 2 | Per-port write (1) or read (0) |
| reqAddr | input | 2*AW | Per-port word address, port 0 in the low bits |
| reqWdata | input | 2*DW | Per-port write data, port 0 in the low bits |
| respValid | output | 2 | One-cycle response pulse per port |
| respData | output | DW | Response word |
| busCmd | output | 3 | Bus command: 0 idle, 1 READ, 2 RFO, 3 INVALIDATE, 4 WRITEBACK |
| busSrc | output | 1 | Port whose cache drives the bus |
| memWe | output | 1 | Memory write enable |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data, combinational on memAddr |

## Verification
The bench builds the block with AW=6, DW=16 and LINES=4. With two index bits, addresses 4 and 12 share frame 0, so a short sequence reaches both eviction cases. In one of them an owned line is evicted by a write miss; in the other, by a read miss. The small data width keeps the expected words readable. The sequence also reaches both intervention cases, where an owner answers a remote READ and where it answers a remote READ-FOR-OWNERSHIP. It ends with a simultaneous write and read of the same block, which exercises priority together with an intervention.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_OWN = 2'd2
  } lineState_e;

  typedef enum logic [2:0] {
    BUS_IDLE = 3'd0,
    BUS_READ = 3'd1,
    BUS_RFO  = 3'd2,
    BUS_INV  = 3'd3,
    BUS_WB   = 3'd4
  } busCmd_e;

  typedef struct packed {
    logic    doWb;
    logic    doAccess;
    logic    sel;
    busCmd_e cmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] addr,
  input  logic          isWrite,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] memRdata,
  output logic          selHit,
  output logic          selOwn,
  output logic          victimDirty,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] respData
);

  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  lineState_e        stArr  [2][LINES];
  logic [TW-1:0]     tagArr [2][LINES];
  logic [DW-1:0]     datArr [2][LINES];

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  logic [1:0]    hitV, ownV, dirtyV;
  logic          oth;
  logic          othOwn;
  logic [DW-1:0] fillData, resultData;

  assign idx = addr[IW-1:0];
  assign tag = addr[AW-1:IW];
  assign oth = ~strobe.sel;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_cache
      assign hitV[c]   = (stArr[c][idx] != LINE_INV) && (tagArr[c][idx] == tag);
      assign ownV[c]   = hitV[c] && (stArr[c][idx] == LINE_OWN);
      assign dirtyV[c] = (stArr[c][idx] == LINE_OWN) && (tagArr[c][idx] != tag);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < LINES; i++) begin
            stArr[c][i]  <= LINE_INV;
            tagArr[c][i] <= '0;
            datArr[c][i] <= '0;
          end
        end else if (strobe.sel == 1'(c)) begin
          if (strobe.doWb) begin
            stArr[c][idx] <= LINE_INV;
          end else if (strobe.doAccess) begin
            if (isWrite) begin
              stArr[c][idx]  <= LINE_OWN;
              tagArr[c][idx] <= tag;
              datArr[c][idx] <= wdata;
            end else if (!hitV[c]) begin
              stArr[c][idx]  <= LINE_SHR;
              tagArr[c][idx] <= tag;
              datArr[c][idx] <= fillData;
            end
          end
        end else if (strobe.doAccess && hitV[c]) begin
          if (strobe.cmd == BUS_READ) begin
            stArr[c][idx] <= LINE_SHR;
          end else if (strobe.cmd == BUS_RFO || strobe.cmd == BUS_INV) begin
            stArr[c][idx] <= LINE_INV;
          end
        end
      end
    end
  endgenerate

  assign selHit      = hitV[strobe.sel];
  assign selOwn      = ownV[strobe.sel];
  assign victimDirty = dirtyV[strobe.sel];
  assign othOwn      = ownV[oth];

  assign fillData   = othOwn ? datArr[oth][idx] : memRdata;
  assign resultData = isWrite ? wdata : (selHit ? datArr[strobe.sel][idx] : fillData);

  assign memWe    = strobe.doWb || (strobe.doAccess && strobe.cmd == BUS_READ && othOwn);
  assign memAddr  = strobe.doWb ? {tagArr[strobe.sel][idx], idx} : addr;
  assign memWdata = strobe.doWb ? datArr[strobe.sel][idx] : datArr[oth][idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
    end else if (strobe.doAccess) begin
      respData <= resultData;
    end
  end

endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  reqValid,
  input  logic        isWrite,
  input  logic        selHit,
  input  logic        selOwn,
  input  logic        victimDirty,
  output ctrlStrobe_t strobe,
  output logic [1:0]  respValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_ACC, ST_RESP} fsm_e;

  fsm_e    state;
  logic    curSel;
  busCmd_e accessCmd;

  always_comb begin
    if (isWrite) begin
      accessCmd = selOwn ? BUS_IDLE : (selHit ? BUS_INV : BUS_RFO);
    end else begin
      accessCmd = selHit ? BUS_IDLE : BUS_READ;
    end
  end

  always_comb begin
    strobe     = '0;
    strobe.sel = curSel;
    strobe.cmd = BUS_IDLE;
    if (state == ST_CHK && victimDirty) begin
      strobe.doWb = 1'b1;
      strobe.cmd  = BUS_WB;
    end else if (state == ST_CHK || state == ST_ACC) begin
      strobe.doAccess = 1'b1;
      strobe.cmd      = accessCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curSel <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (|reqValid) begin
          curSel <= ~reqValid[0];
          state  <= ST_CHK;
        end
        ST_CHK:  state <= victimDirty ? ST_ACC : ST_RESP;
        ST_ACC:  state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign respValid = (state == ST_RESP) ? (curSel ? 2'b10 : 2'b01) : 2'b00;

endmodule

// File: rtl/coh_wbown_top.sv
module coh_wbown_top
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      reqValid,
  input  logic [1:0]      reqWrite,
  input  logic [2*AW-1:0] reqAddr,
  input  logic [2*DW-1:0] reqWdata,
  output logic [1:0]      respValid,
  output logic [DW-1:0]   respData,
  output logic [2:0]      busCmd,
  output logic            busSrc,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata
);

  ctrlStrobe_t   strobe;
  logic          selHit, selOwn, victimDirty;
  logic          selWrite;
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selWdata;

  assign selWrite = reqWrite[strobe.sel];
  assign selAddr  = strobe.sel ? reqAddr[AW +: AW]  : reqAddr[0 +: AW];
  assign selWdata = strobe.sel ? reqWdata[DW +: DW] : reqWdata[0 +: DW];

  coh_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .isWrite     (selWrite),
    .selHit      (selHit),
    .selOwn      (selOwn),
    .victimDirty (victimDirty),
    .strobe      (strobe),
    .respValid   (respValid)
  );

  coh_datapath #(.AW(AW), .DW(DW), .LINES(LINES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addr        (selAddr),
    .isWrite     (selWrite),
    .wdata       (selWdata),
    .memRdata    (memRdata),
    .selHit      (selHit),
    .selOwn      (selOwn),
    .victimDirty (victimDirty),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .respData    (respData)
  );

  assign busCmd = strobe.cmd;
  assign busSrc = strobe.sel;

endmodule

// File: rtl/coh_wbown_chk.sv
module coh_wbown_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    respValid,
  input logic [2:0]    busCmd,
  input logic          busSrc,
  input logic          memWe
);

  AST_WB_DRIVES_MEM: assert property (@(posedge clk) disable iff (!rstN)
    busCmd == 3'd4 |-> memWe); // R8

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    busCmd == 3'd4 |=> (busCmd == 3'd1 || busCmd == 3'd2) && busSrc == $past(busSrc)); // R8

  AST_MEM_WRITE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busCmd == 3'd4 || busCmd == 3'd1)); // R6

  AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(respValid)); // R10

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    |respValid |=> respValid == 2'b00); // R10

  AST_NO_BUS_WITH_RESP: assert property (@(posedge clk) disable iff (!rstN)
    |respValid |-> busCmd == 3'd0); // R9

endmodule

bind coh_wbown_top coh_wbown_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .respValid (respValid),
  .busCmd    (busCmd),
  .busSrc    (busSrc),
  .memWe     (memWe)
);

// File: tb/coh_wbown_top_tb.sv
module coh_wbown_top_tb;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LINES = 4;

  typedef struct {
    logic [31:0] ev;
    string       tag;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      reqValid = '0;
  logic [1:0]      reqWrite = '0;
  logic [2*AW-1:0] reqAddr = '0;
  logic [2*DW-1:0] reqWdata = '0;
  logic [1:0]      respValid;
  logic [DW-1:0]   respData;
  logic [2:0]      busCmd;
  logic            busSrc;
  logic            memWe;
  logic [AW-1:0]   memAddr;
  logic [DW-1:0]   memWdata;
  logic [DW-1:0]   memRdata;
  logic [DW-1:0]   memArr [64];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  coh_wbown_top #(.AW(AW), .DW(DW), .LINES(LINES)) u_dut (
    .clk, .rstN, .reqValid, .reqWrite, .reqAddr, .reqWdata,
    .respValid, .respData, .busCmd, .busSrc,
    .memWe, .memAddr, .memWdata, .memRdata
  );

  assign memRdata = memArr[memAddr];
  always @(posedge clk) if (memWe) memArr[memAddr] <= memWdata;

  function automatic logic [31:0] evBus(input int cmd, input int src);
    return {4'd1, 4'(src), 8'd0, 16'(cmd)};
  endfunction
  function automatic logic [31:0] evMem(input int a, input int d);
    return {4'd2, 4'd0, 8'(a), 16'(d)};
  endfunction
  function automatic logic [31:0] evResp(input int p, input int d);
    return {4'd3, 4'(p), 8'd0, 16'(d)};
  endfunction

  task automatic expect_ev(input logic [31:0] ev, input string tag);
    expItem_t it;
    it.ev = ev;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe(input logic [31:0] act);
    expItem_t it;
    if (expQ.size() == 0) begin
      vectors++;
      miscompares++;
      $display("FAIL R6 unexpected event actual=%h expected=none", act);
    end else begin
      it = expQ.pop_front();
      check(it.tag, act, it.ev);
    end
  endtask

  // monitor: compares produced events with the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (busCmd != 3'd0) observe(evBus(int'(busCmd), int'(busSrc)));
      if (memWe) observe(evMem(int'(memAddr), int'(memWdata)));
      for (int p = 0; p < 2; p++)
        if (respValid[p]) observe(evResp(p, int'(respData)));
    end
  end

  task automatic run(input int p, input bit w, input int a, input int d);
    @(negedge clk);
    reqValid[p] = 1'b1;
    reqWrite[p] = w;
    reqAddr[p*AW +: AW] = AW'(a);
    reqWdata[p*DW +: DW] = DW'(d);
    do @(negedge clk); while (!respValid[p]);
    reqValid[p] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) memArr[i] = 16'(i * 3);
    memArr[4] = 16'd5;
    memArr[12] = 16'h0033;
    memArr[5] = 16'h0011;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 resp idle", {30'd0, respValid}, 32'd0);
    check("R1 bus idle", {29'd0, busCmd}, 32'd0);
    check("R1 no mem write", {31'd0, memWe}, 32'd0);
    rstN = 1'b1;

    expect_ev(evBus(1, 0), "R2"); expect_ev(evResp(0, 5), "R2");
    run(0, 0, 4, 0);
    expect_ev(evBus(1, 1), "R2"); expect_ev(evResp(1, 5), "R2");
    run(1, 0, 4, 0);
    expect_ev(evBus(3, 1), "R4"); expect_ev(evResp(1, 7), "R10");
    run(1, 1, 4, 7);
    check("R6 memory stale after write", 32'(memArr[4]), 32'd5);
    expect_ev(evResp(1, 7), "R3");
    run(1, 0, 4, 0);
    expect_ev(evResp(1, 9), "R6");
    run(1, 1, 4, 9);
    expect_ev(evBus(2, 0), "R5"); expect_ev(evResp(0, 16'h0B), "R5");
    run(0, 1, 4, 16'h0B);
    check("R5 no memory write on RFO", 32'(memArr[4]), 32'd5);
    expect_ev(evBus(1, 1), "R7"); expect_ev(evMem(4, 16'h0B), "R7");
    expect_ev(evResp(1, 16'h0B), "R7");
    run(1, 0, 4, 0);
    expect_ev(evResp(0, 16'h0B), "R7");
    run(0, 0, 4, 0);
    expect_ev(evBus(3, 0), "R7"); expect_ev(evResp(0, 16'h0C), "R7");
    run(0, 1, 4, 16'h0C);
    expect_ev(evBus(4, 0), "R8"); expect_ev(evMem(4, 16'h0C), "R8");
    expect_ev(evBus(2, 0), "R8"); expect_ev(evResp(0, 16'h44), "R8");
    run(0, 1, 12, 16'h44);
    expect_ev(evBus(1, 1), "R4"); expect_ev(evResp(1, 16'h0C), "R4");
    run(1, 0, 4, 0);
    expect_ev(evBus(4, 0), "R8"); expect_ev(evMem(12, 16'h44), "R8");
    expect_ev(evBus(1, 0), "R8"); expect_ev(evResp(0, 16'h0C), "R8");
    run(0, 0, 4, 0);
    expect_ev(evBus(2, 1), "R5"); expect_ev(evResp(1, 16'h22), "R5");
    run(1, 1, 5, 16'h22);
    expect_ev(evBus(1, 0), "R7"); expect_ev(evMem(5, 16'h22), "R7");
    expect_ev(evResp(0, 16'h22), "R7");
    run(0, 0, 5, 0);
    // R9: simultaneous requests, port 0 first
    expect_ev(evBus(3, 0), "R9"); expect_ev(evResp(0, 16'h66), "R9");
    expect_ev(evBus(1, 1), "R9"); expect_ev(evMem(5, 16'h66), "R9");
    expect_ev(evResp(1, 16'h66), "R9");
    fork
      run(0, 1, 5, 16'h66);
      run(1, 0, 5, 0);
    join
    repeat (4) @(negedge clk);
    check("R8 victim reached memory", 32'(memArr[12]), 32'h44);
    check("R6 final memory word", 32'(memArr[4]), 32'h0C);
    check("R10 scoreboard drained", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule